// File: doc/BRIEF.md
# Raster Scan Timing Generator

This block produces the frame timing for a tile-based video display processor. Two counters run on the pixel clock. A dot counter steps across each scanline, and a line counter steps down the frame. The default frame is 341 dots by 262 lines, of which 256 dots by 240 lines are visible. The block reports the current position. It also drives flags for the visible area, vertical blank and the pre-render line, plus a window signal that tells the tile fetch pipeline when to run memory accesses.

At the end of the visible region the block raises a non-maskable interrupt request to the host CPU. The host can mask this request through an enable bit in a control register, which it writes over a small write-only register port. The pixel clock runs at three times the CPU rate, so the block also supplies a CPU clock enable that divides the pixel clock by three.

Top module: `raster_timing_gen`

## Requirements
- R1: While the synchronous reset is high and in the first cycle after it, dot and line are 0, vblank, frame_irq, visible and prerender are 0, the interrupt enable is cleared, and cpu_ce is 1.
- R2: The dot counter advances by one each pixel clock and wraps from DOTS_PER_LINE-1 to 0. On that wrap the line counter advances by one, and it wraps from LINES_PER_FRAME-1 to 0. A reset applied at any position returns both counters to 0.
- R3: visible is high exactly when dot is in 1..VIS_DOTS and line is below VIS_LINES.
- R4: vblank goes high when the position reaches dot 1 of line VIS_LINES+1. It goes low when the position reaches dot 1 of line LINES_PER_FRAME-1, so it is high from (VIS_LINES+1, 1) through (LINES_PER_FRAME-1, 0) inclusive.
- R5: prerender is high exactly when line equals LINES_PER_FRAME-1.
- R6: frame_irq is high exactly while vblank is high and the enable bit is set. The enable bit is bit 7 of the control register at reg_addr 0. When a write sets that bit while vblank is already high, frame_irq is high in the very next cycle. A write that clears the bit drops frame_irq in the next cycle.
- R7: Writes to any reg_addr other than 0 leave the enable bit unchanged. So does a write to address 0 while reg_we is low. A write to address 0 with bit 7 clear leaves the enable cleared, whatever the other bits hold.
- R8: fetch_active is high on lines below VIS_LINES and on the pre-render line, for dots 1..VIS_DOTS and for dots PF_FIRST..PF_LAST.
- R9: cpu_ce is high once every CPU_DIV pixel clocks. Counting cycles from reset release as n = 0, 1, 2, ..., it is high when n mod CPU_DIV equals 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Host register address (0 = control register) |
| reg_wdata | input | 8 | Host write data; bit 7 of register 0 enables the interrupt |
| dot | output | DOT_W | Current dot within the line |
| line | output | LINE_W | Current scanline |
| visible | output | 1 | Position lies in the visible picture |
| vblank | output | 1 | Vertical-blank flag |
| prerender | output | 1 | Current line is the pre-render line |
| fetch_active | output | 1 | Tile fetch window for the fetch pipeline |
| frame_irq | output | 1 | End-of-frame interrupt request, active high |
| cpu_ce | output | 1 | CPU clock enable, one pixel clock in CPU_DIV |

## Verification
The bench builds the block with a shrunken frame: 24 dots by 14 lines, 16 by 8 visible, and a fetch prefetch window at dots 19..22. CPU_DIV stays at 3. With these values, every wrap, the vertical-blank set and clear points, the pre-render line and several whole frames all fit in a few thousand cycles, and every dot is compared against an independent position model. The same sizes put vertical blank within reach many times. This lets the bench test masking, immediate raising on enable, writes to other addresses, and a reset in the middle of a frame.

// File: rtl/raster_pkg.sv
package raster_pkg;

  // Host register address of the control register
  localparam logic [2:0] CTRL_REG_ADDR = 3'd0;
  // Bit of the control register that unmasks the frame interrupt
  localparam int         IRQ_EN_BIT    = 7;

  // Inclusive range test used for all window decodes
  function automatic logic in_span(input int v, input int lo, input int hi);
    return (v >= lo) && (v <= hi);
  endfunction

  // Line belongs to the rendering set (visible lines or the pre-render line)
  function automatic logic render_line(input int ln, input int vis_lines,
                                       input int total_lines);
    return (ln < vis_lines) || (ln == total_lines - 1);
  endfunction

endpackage

// File: rtl/raster_counters.sv
module raster_counters #(
  parameter int DOTS   = 341,
  parameter int LINES  = 262,
  parameter int DOT_W  = 9,
  parameter int LINE_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  output logic [DOT_W-1:0]  dot,
  output logic [LINE_W-1:0] line,
  output logic              line_end,
  output logic              frame_end
);

  localparam logic [DOT_W-1:0]  LAST_DOT  = DOT_W'(DOTS - 1);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);

  assign line_end  = (dot == LAST_DOT);
  assign frame_end = line_end && (line == LAST_LINE);

  always_ff @(posedge clk) begin
    if (rst) begin
      dot  <= '0;
      line <= '0;
    end else if (line_end) begin
      dot  <= '0;
      line <= frame_end ? '0 : line + LINE_W'(1);
    end else begin
      dot  <= dot + DOT_W'(1);
    end
  end

endmodule

// File: rtl/raster_vblank.sv
module raster_vblank #(
  parameter int VBL_LINE = 241,
  parameter int PRE_LINE = 261,
  parameter int DOT_W    = 9,
  parameter int LINE_W   = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DOT_W-1:0]  dot,
  input  logic [LINE_W-1:0] line,
  output logic              vbl_set,
  output logic              vbl_clr,
  output logic              vblank
);

  // Events fire one dot early so the flag is valid when the position shows dot 1
  assign vbl_set = (int'(line) == VBL_LINE) && (dot == '0);
  assign vbl_clr = (int'(line) == PRE_LINE) && (dot == '0);

  always_ff @(posedge clk) begin
    if (rst)          vblank <= 1'b0;
    else if (vbl_set) vblank <= 1'b1;
    else if (vbl_clr) vblank <= 1'b0;
  end

endmodule

// File: rtl/raster_host_ctrl.sv
module raster_host_ctrl
  import raster_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       vblank,
  output logic       ctrl_wr,
  output logic       irq_en,
  output logic       frame_irq
);

  assign ctrl_wr = reg_we && (reg_addr == CTRL_REG_ADDR);

  always_ff @(posedge clk) begin
    if (rst)          irq_en <= 1'b0;
    else if (ctrl_wr) irq_en <= reg_wdata[IRQ_EN_BIT];
  end

  // Level request: raised at once if enabled inside vertical blank
  assign frame_irq = vblank && irq_en;

endmodule

// File: rtl/cpu_clk_div.sv
module cpu_clk_div #(
  parameter int DIV = 3
) (
  input  logic clk,
  input  logic rst,
  output logic ce
);

  generate
    if (DIV <= 1) begin : g_pass
      assign ce = 1'b1;
    end else begin : g_count
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] phase;
      always_ff @(posedge clk) begin
        if (rst)                phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + PW'(1);
      end
      assign ce = (phase == '0);
    end
  endgenerate

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int DOTS_PER_LINE   = 341,
  parameter int LINES_PER_FRAME = 262,
  parameter int VIS_DOTS        = 256,
  parameter int VIS_LINES       = 240,
  parameter int PF_FIRST        = 321,
  parameter int PF_LAST         = 336,
  parameter int CPU_DIV         = 3,
  parameter int DOT_W           = $clog2(DOTS_PER_LINE),
  parameter int LINE_W          = $clog2(LINES_PER_FRAME)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [DOT_W-1:0]  dot,
  output logic [LINE_W-1:0] line,
  output logic              visible,
  output logic              vblank,
  output logic              prerender,
  output logic              fetch_active,
  output logic              frame_irq,
  output logic              cpu_ce
);

  localparam int VBL_LINE = VIS_LINES + 1;
  localparam int PRE_LINE = LINES_PER_FRAME - 1;

  // Named internal events, visible to the bound checker
  logic line_end, frame_end, vbl_set, vbl_clr, ctrl_wr, irq_en;

  raster_counters #(
    .DOTS(DOTS_PER_LINE), .LINES(LINES_PER_FRAME), .DOT_W(DOT_W), .LINE_W(LINE_W)
  ) i_counters (
    .clk(clk), .rst(rst), .dot(dot), .line(line),
    .line_end(line_end), .frame_end(frame_end)
  );

  raster_vblank #(
    .VBL_LINE(VBL_LINE), .PRE_LINE(PRE_LINE), .DOT_W(DOT_W), .LINE_W(LINE_W)
  ) i_vblank (
    .clk(clk), .rst(rst), .dot(dot), .line(line),
    .vbl_set(vbl_set), .vbl_clr(vbl_clr), .vblank(vblank)
  );

  raster_host_ctrl i_host (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .vblank(vblank), .ctrl_wr(ctrl_wr),
    .irq_en(irq_en), .frame_irq(frame_irq)
  );

  cpu_clk_div #(.DIV(CPU_DIV)) i_cpu_div (
    .clk(clk), .rst(rst), .ce(cpu_ce)
  );

  // Window decodes from the current position
  always_comb begin
    visible      = (int'(line) < VIS_LINES) && in_span(int'(dot), 1, VIS_DOTS);
    prerender    = (int'(line) == PRE_LINE);
    fetch_active = render_line(int'(line), VIS_LINES, LINES_PER_FRAME) &&
                   (in_span(int'(dot), 1, VIS_DOTS) ||
                    in_span(int'(dot), PF_FIRST, PF_LAST));
  end

endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
  parameter int DOTS_PER_LINE   = 341,
  parameter int LINES_PER_FRAME = 262,
  parameter int VIS_LINES       = 240,
  parameter int CPU_DIV         = 3,
  parameter int DOT_W           = 9,
  parameter int LINE_W          = 9
) (
  input logic              clk,
  input logic              rst,
  input logic [DOT_W-1:0]  dot,
  input logic [LINE_W-1:0] line,
  input logic              visible,
  input logic              vblank,
  input logic              prerender,
  input logic              frame_irq,
  input logic              cpu_ce,
  input logic              vbl_clr,
  input logic              ctrl_wr,
  input logic              irq_en,
  input logic              reg_we,
  input logic [2:0]        reg_addr,
  input logic [7:0]        reg_wdata
);

  localparam logic [DOT_W-1:0]  LAST_DOT  = DOT_W'(DOTS_PER_LINE - 1);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES_PER_FRAME - 1);
  localparam logic [LINE_W-1:0] VBL_L     = LINE_W'(VIS_LINES + 1);

  assert_dot_step_R2: assert property (@(posedge clk) disable iff (rst)
    (dot != LAST_DOT) |=> (dot == $past(dot) + DOT_W'(1)) && $stable(line));

  assert_line_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (dot == LAST_DOT) |=> (dot == '0) &&
      (line == (($past(line) == LAST_LINE) ? '0 : $past(line) + LINE_W'(1))));

  assert_visible_lines_R3: assert property (@(posedge clk) disable iff (rst)
    visible |-> (int'(line) < VIS_LINES) && !prerender);

  assert_vblank_set_R4: assert property (@(posedge clk) disable iff (rst)
    (line == VBL_L && dot == '0) |=> vblank);

  assert_vblank_clr_R4: assert property (@(posedge clk) disable iff (rst)
    vbl_clr |=> !vblank);

  assert_prerender_R5: assert property (@(posedge clk) disable iff (rst)
    prerender |-> (line == LAST_LINE));

  assert_irq_needs_vblank_R6: assert property (@(posedge clk) disable iff (rst)
    frame_irq |-> vblank);

  assert_irq_immediate_R6: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 3'd0 && reg_wdata[7] && vblank && !vbl_clr) |=> frame_irq);

  assert_other_addr_R7: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_wr) |=> $stable(irq_en));

  assert_ce_gap_R9: assert property (@(posedge clk) disable iff (rst)
    (cpu_ce && CPU_DIV > 1) |=> !cpu_ce);

endmodule

bind raster_timing_gen raster_timing_chk #(
  .DOTS_PER_LINE(DOTS_PER_LINE), .LINES_PER_FRAME(LINES_PER_FRAME),
  .VIS_LINES(VIS_LINES), .CPU_DIV(CPU_DIV), .DOT_W(DOT_W), .LINE_W(LINE_W)
) i_chk (
  .clk(clk), .rst(rst), .dot(dot), .line(line), .visible(visible),
  .vblank(vblank), .prerender(prerender), .frame_irq(frame_irq),
  .cpu_ce(cpu_ce), .vbl_clr(vbl_clr), .ctrl_wr(ctrl_wr), .irq_en(irq_en),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/test_raster_timing_gen.sv
module test_raster_timing_gen;

  localparam int D   = 24;
  localparam int L   = 14;
  localparam int VD  = 16;
  localparam int VL  = 8;
  localparam int PF1 = 19;
  localparam int PF2 = 22;
  localparam int DIV = 3;
  localparam int DW  = $clog2(D);
  localparam int LW  = $clog2(L);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_addr = 3'd0;
  logic [7:0]    reg_wdata = 8'd0;
  logic [DW-1:0] dot;
  logic [LW-1:0] line;
  logic visible, vblank, prerender, fetch_active, frame_irq, cpu_ce;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Independent model state
  int m_dot = 0, m_line = 0, m_n = 0;
  bit m_en = 0;

  always #2.5 clk = ~clk;

  raster_timing_gen #(
    .DOTS_PER_LINE(D), .LINES_PER_FRAME(L), .VIS_DOTS(VD), .VIS_LINES(VL),
    .PF_FIRST(PF1), .PF_LAST(PF2), .CPU_DIV(DIV)
  ) i_raster_timing_gen (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .dot(dot), .line(line), .visible(visible),
    .vblank(vblank), .prerender(prerender), .fetch_active(fetch_active),
    .frame_irq(frame_irq), .cpu_ce(cpu_ce)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (line %0d dot %0d)",
               req, what, act, exp, m_line, m_dot);
    end
  endtask

  function automatic bit exp_vblank();
    return (m_line == VL + 1 && m_dot >= 1) || (m_line > VL + 1 && m_line < L - 1) ||
           (m_line == L - 1 && m_dot == 0);
  endfunction

  task automatic compare_all();
    bit vb, rl;
    vb = exp_vblank();
    rl = (m_line < VL) || (m_line == L - 1);
    check("R2", "dot", int'(dot), m_dot);
    check("R2", "line", int'(line), m_line);
    check("R3", "visible", visible, (m_line < VL) && m_dot >= 1 && m_dot <= VD);
    check("R4", "vblank", vblank, vb);
    check("R5", "prerender", prerender, m_line == L - 1);
    check("R6", "frame_irq", frame_irq, vb && m_en);
    check("R8", "fetch_active", fetch_active,
          rl && ((m_dot >= 1 && m_dot <= VD) || (m_dot >= PF1 && m_dot <= PF2)));
    check("R9", "cpu_ce", cpu_ce, (m_n % DIV) == 0);
  endtask

  // One pixel clock: capture inputs, advance the model, compare at negedge
  task automatic step();
    @(posedge clk);
    if (reg_we && reg_addr == 3'd0) m_en = reg_wdata[7];
    m_n++;
    if (m_dot == D - 1) begin
      m_dot = 0;
      m_line = (m_line == L - 1) ? 0 : m_line + 1;
    end else m_dot++;
    @(negedge clk);
    compare_all();
  endtask

  task automatic run_to(input int ln, input int dt);
    while (!(m_line == ln && m_dot == dt)) step();
  endtask

  task automatic host_write(input logic [2:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 1'b0; reg_addr = 3'd0; reg_wdata = 8'd0;
  endtask

  // R1: reset state, also used for a mid-frame reset
  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "dot in reset", int'(dot), 0);
    check("R1", "line in reset", int'(line), 0);
    check("R1", "vblank in reset", vblank, 0);
    check("R1", "irq in reset", frame_irq, 0);
    rst = 1'b0;
    m_dot = 0; m_line = 0; m_n = 0; m_en = 0;
    check("R1", "cpu_ce after reset", cpu_ce, 1);
    compare_all();
  endtask

  // R2..R5, R8, R9: two whole frames with the interrupt masked
  task automatic t_scan_masked();
    repeat (2 * D * L) step();
  endtask

  // R6: enabling inside vertical blank raises the request on the next cycle
  task automatic t_enable_in_vblank();
    run_to(VL + 2, 3);
    check("R6", "irq masked in vblank", frame_irq, 0);
    host_write(3'd0, 8'h80);
    check("R6", "irq immediate on enable", frame_irq, 1);
    run_to(L - 1, 1);
    check("R6", "irq drops with vblank", frame_irq, 0);
    run_to(VL + 1, 1);
    check("R6", "irq on next frame end", frame_irq, 1);
    host_write(3'd0, 8'h00);
    check("R6", "irq drops on disable", frame_irq, 0);
  endtask

  // R7: other addresses, no strobe, and bit 7 clear leave the enable off
  task automatic t_ignored_writes();
    run_to(VL + 2, 0);
    host_write(3'd3, 8'hFF);
    check("R7", "write to addr 3 ignored", frame_irq, 0);
    host_write(3'd1, 8'h80);
    check("R7", "write to addr 1 ignored", frame_irq, 0);
    host_write(3'd0, 8'h7F);
    check("R7", "bit7 clear keeps mask", frame_irq, 0);
    reg_addr = 3'd0; reg_wdata = 8'h80;
    step();
    reg_wdata = 8'h00;
    check("R7", "no strobe ignored", frame_irq, 0);
    repeat (D) step();
  endtask

  // R2: reset in the middle of a visible line
  task automatic t_mid_reset();
    host_write(3'd0, 8'h80);
    run_to(3, 7);
    t_reset();
    check("R2", "mid reset dot", int'(dot), 0);
    check("R2", "mid reset line", int'(line), 0);
    run_to(VL + 1, 1);
    check("R1", "enable cleared by reset", frame_irq, 0);
  endtask

  initial begin
    t_reset();
    t_scan_masked();
    t_enable_in_vblank();
    t_ignored_writes();
    t_mid_reset();
    repeat (D * L) step();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule